// File: doc/BRIEF.md
# Pipeline Hazard Interlock Controller

This block is the stall and bubble control for a five-stage in-order pipeline: fetch, decode, operand fetch, execute, writeback. It keeps a small control tag for each instruction in flight (valid bit, source and destination register indices, memory read and write flags). From those tags it works out, in the same cycle, whether the pipeline moves forward, holds its front part, or waits for a multi-cycle execute unit. Results are never forwarded, so every dependency is resolved by waiting.

Three conditions stop the front of the pipeline. The first is a register read-after-write dependency: an instruction in operand fetch reads a register that a valid instruction in execute or writeback will write. The second is a structural conflict on the single data-memory port, when an operand-fetch read meets a writeback write. The third is an execute unit that reports it is busy. On a dependency or a port conflict, fetch, decode and operand fetch hold and a bubble enters execute. When execute is busy, every stage up to and including execute holds and a bubble enters writeback. The busy case takes precedence over the other two. All control outputs are combinational functions of the current stage tags and inputs.

Top module: `pipe_interlock`

## Requirements
- R1: On synchronous active-low reset, all stage valid bits clear, and stall_front, hold_ex, bubble_ex, bubble_wb, mem_rd_en, mem_wr_en and reg_we are all low.
- R2: When nothing stops the pipeline, an instruction presented with in_valid high while stall_front is low enters decode at the next edge. It then moves one stage per cycle and shows as of_valid, then ex_valid, then wb_valid.
- R3: A register hazard exists when a valid operand-fetch instruction has either source index equal to the destination of a valid execute or writeback instruction. While the hazard exists and execute is not busy, stall_front and bubble_ex are high, and execute holds an invalid slot at the next edge. A consumer directly behind its producer therefore waits exactly two cycles.
- R4: Destination register 0 never causes a hazard, and stages whose valid bit is clear never cause one. A NOP is a valid instruction with destination 0 and no memory flags, and it never causes a stall.
- R5: When ex_busy is high and execute holds a valid instruction, stall_front, hold_ex and bubble_wb are high and bubble_ex is low, even if a hazard is also present. ex_busy has no effect while execute is empty.
- R6: mem_wr_en equals a valid writeback instruction with its memory-write flag set. If a valid operand-fetch instruction with its memory-read flag set meets such a write, the front stalls and a bubble enters execute. mem_rd_en is high only when the operand-fetch reader advances, so mem_rd_en and mem_wr_en are never high together.
- R7: reg_we is high exactly when writeback holds a valid instruction that has a nonzero destination and no memory-write flag; wb_dst shows that destination.
- R8: While stall_front is high, the in_* fetch inputs are ignored; the instruction already in decode stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Fetched instruction present |
| in_src1 | input | REG_W | First source register index |
| in_src2 | input | REG_W | Second source register index |
| in_dst | input | REG_W | Destination register index (0 = none) |
| in_mem_rd | input | 1 | Instruction reads a memory operand in operand fetch |
| in_mem_wr | input | 1 | Instruction writes its result to memory in writeback |
| ex_busy | input | 1 | Execute unit needs a further cycle |
| stall_front | output | 1 | Fetch, decode and operand fetch hold |
| hold_ex | output | 1 | Execute stage holds |
| bubble_ex | output | 1 | Invalid slot enters execute |
| bubble_wb | output | 1 | Invalid slot enters writeback |
| mem_rd_en | output | 1 | Data-memory read issued by operand fetch |
| mem_wr_en | output | 1 | Data-memory write issued by writeback |
| reg_we | output | 1 | Register file write in writeback |
| wb_dst | output | REG_W | Writeback destination index |
| of_valid | output | 1 | Operand-fetch stage holds an instruction |
| ex_valid | output | 1 | Execute stage holds an instruction |
| wb_valid | output | 1 | Writeback stage holds an instruction |

## Verification
The hardest case to reach from the ports is several stop conditions at once. Examples are a busy execute unit on top of a pending register dependency, or a memory read that meets a write while a dependency also holds. Each needs instructions placed exactly two or three slots apart. Directed sequences build these spacings one at a time and count the stall cycles that result. A long random phase then draws register indices from a very small set, sets memory flags and busy often, and compares every output in every cycle with a bench model of the stage tags. This makes overlapping conditions frequent.

// File: rtl/pi_pkg.sv
// Shared definitions for the pipeline interlock.
// Assumes a single action is chosen per cycle for the whole pipeline.
package pi_pkg;
    // Pipeline-wide action for one cycle, in priority order BUSY > STALL > ADVANCE
    typedef enum logic [1:0] {
        PI_ADVANCE = 2'd0,
        PI_STALL   = 2'd1,
        PI_BUSY    = 2'd2
    } pi_action_e;
endpackage

// File: rtl/pi_stage_reg.sv
// One pipeline control register: a valid bit plus a tag payload.
// hold keeps the contents, bubble loads an invalid slot, otherwise the
// upstream tag is captured. Assumes hold and bubble are never both high.
module pi_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         bubble,
    input  logic         up_valid,
    input  logic [W-1:0] up_tag,
    output logic         q_valid,
    output logic [W-1:0] q_tag
);
    // Capture, hold or bubble the stage contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
        end else if (!hold) begin
            q_valid <= up_valid & ~bubble;
            q_tag   <= up_tag;
        end
    end
endmodule

// File: rtl/pi_hazard_detect.sv
// Combinational hazard detection. Compares each operand-fetch source with
// each downstream producer (execute, writeback), checks the shared memory
// port and picks the cycle action. Register 0 is never a real destination.
module pi_hazard_detect
    import pi_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             of_valid,
    input  logic [REG_W-1:0] of_src1,
    input  logic [REG_W-1:0] of_src2,
    input  logic             of_mem_rd,
    input  logic             ex_valid,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             wb_valid,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_mem_wr,
    input  logic             ex_busy,
    output pi_action_e       action
);
    localparam int NUM_SRC  = 2;
    localparam int NUM_PROD = 2;

    logic [NUM_SRC-1:0][REG_W-1:0]  src;
    logic [NUM_PROD-1:0][REG_W-1:0] pdst;
    logic [NUM_PROD-1:0]            plive;
    logic [NUM_SRC*NUM_PROD-1:0]    hit;
    logic                           raw_hit;
    logic                           port_hit;

    assign src   = {of_src2, of_src1};
    assign pdst  = {wb_dst, ex_dst};
    assign plive = {wb_valid && (wb_dst != '0), ex_valid && (ex_dst != '0)};

    // One comparator per source/producer pair
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
            assign hit[s*NUM_PROD+p] = plive[p] && (src[s] == pdst[p]);
        end
    end

    assign raw_hit  = of_valid && (|hit);
    assign port_hit = of_valid && of_mem_rd && wb_valid && wb_mem_wr;

    // Select the action; a busy execute overrides any stall
    always_comb begin
        if (ex_valid && ex_busy)      action = PI_BUSY;
        else if (raw_hit || port_hit) action = PI_STALL;
        else                          action = PI_ADVANCE;
    end
endmodule

// File: rtl/pipe_interlock.sv
// Interlock controller for a five-stage in-order pipeline without
// forwarding. Tracks a control tag per stage (decode, operand fetch,
// execute, writeback) and drives hold and bubble controls. The fetch
// stage is outside: it must keep its instruction while stall_front is high.
module pipe_interlock
    import pi_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [REG_W-1:0] in_src1,
    input  logic [REG_W-1:0] in_src2,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_mem_rd,
    input  logic             in_mem_wr,
    input  logic             ex_busy,
    output logic             stall_front,
    output logic             hold_ex,
    output logic             bubble_ex,
    output logic             bubble_wb,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic             reg_we,
    output logic [REG_W-1:0] wb_dst,
    output logic             of_valid,
    output logic             ex_valid,
    output logic             wb_valid
);
    // Front tag: {src1, src2, dst, mem_rd, mem_wr}; back tag: {dst, mem_wr}
    localparam int FRONT_W = 3*REG_W + 2;
    localparam int BACK_W  = REG_W + 1;

    pi_action_e         action;
    logic               id_valid;
    logic [FRONT_W-1:0] in_tag, id_tag, of_tag;
    logic [BACK_W-1:0]  of_back, ex_tag, wb_tag;
    logic [REG_W-1:0]   of_src1, of_src2, ex_dst;
    logic               of_mem_rd, wb_mem_wr;

    assign in_tag  = {in_src1, in_src2, in_dst, in_mem_rd, in_mem_wr};
    assign of_src1 = of_tag[FRONT_W-1 -: REG_W];
    assign of_src2 = of_tag[2*REG_W+1 -: REG_W];
    assign of_back = {of_tag[REG_W+1 -: REG_W], of_tag[0]};
    assign of_mem_rd = of_tag[1];
    assign ex_dst    = ex_tag[BACK_W-1 -: REG_W];
    assign wb_dst    = wb_tag[BACK_W-1 -: REG_W];
    assign wb_mem_wr = wb_tag[0];

    pi_hazard_detect #(.REG_W(REG_W)) u_hazard (
        .of_valid (of_valid),
        .of_src1  (of_src1),
        .of_src2  (of_src2),
        .of_mem_rd(of_mem_rd),
        .ex_valid (ex_valid),
        .ex_dst   (ex_dst),
        .wb_valid (wb_valid),
        .wb_dst   (wb_dst),
        .wb_mem_wr(wb_mem_wr),
        .ex_busy  (ex_busy),
        .action   (action)
    );

    // Decode the cycle action into per-stage controls
    always_comb begin
        hold_ex     = (action == PI_BUSY);
        bubble_wb   = (action == PI_BUSY);
        bubble_ex   = (action == PI_STALL);
        stall_front = (action != PI_ADVANCE);
    end

    assign mem_rd_en = of_valid && of_mem_rd && !stall_front;
    assign mem_wr_en = wb_valid && wb_mem_wr;
    assign reg_we    = wb_valid && !wb_mem_wr && (wb_dst != '0);

    pi_stage_reg #(.W(FRONT_W)) u_id (
        .clk(clk), .rst_n(rst_n), .hold(stall_front), .bubble(1'b0),
        .up_valid(in_valid), .up_tag(in_tag),
        .q_valid(id_valid), .q_tag(id_tag)
    );

    pi_stage_reg #(.W(FRONT_W)) u_of (
        .clk(clk), .rst_n(rst_n), .hold(stall_front), .bubble(1'b0),
        .up_valid(id_valid), .up_tag(id_tag),
        .q_valid(of_valid), .q_tag(of_tag)
    );

    pi_stage_reg #(.W(BACK_W)) u_ex (
        .clk(clk), .rst_n(rst_n), .hold(hold_ex), .bubble(bubble_ex),
        .up_valid(of_valid), .up_tag(of_back),
        .q_valid(ex_valid), .q_tag(ex_tag)
    );

    pi_stage_reg #(.W(BACK_W)) u_wb (
        .clk(clk), .rst_n(rst_n), .hold(1'b0), .bubble(bubble_wb),
        .up_valid(ex_valid), .up_tag(ex_tag),
        .q_valid(wb_valid), .q_tag(wb_tag)
    );
endmodule

// File: rtl/pipe_interlock_chk.sv
// Property checker for pipe_interlock, attached through bind.
// Observes ports only; assumes synchronous active-low reset.
module pipe_interlock_chk (
    input logic clk,
    input logic rst_n,
    input logic ex_busy,
    input logic stall_front,
    input logic hold_ex,
    input logic bubble_ex,
    input logic bubble_wb,
    input logic mem_rd_en,
    input logic mem_wr_en,
    input logic reg_we,
    input logic of_valid,
    input logic ex_valid,
    input logic wb_valid
);
    // R6
    mem_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R5
    busy_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_busy && ex_valid) |-> (hold_ex && bubble_wb && stall_front && !bubble_ex));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ex |=> ex_valid);

    // R3
    bubble_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ex |-> stall_front);

    // R3
    bubble_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ex |=> !ex_valid);

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (of_valid && !stall_front) |=> ex_valid);

    // R5
    wb_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_wb |=> !wb_valid);

    // R7
    reg_we_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (wb_valid && !mem_wr_en));
endmodule

bind pipe_interlock pipe_interlock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ex_busy(ex_busy),
    .stall_front(stall_front), .hold_ex(hold_ex), .bubble_ex(bubble_ex),
    .bubble_wb(bubble_wb), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .reg_we(reg_we), .of_valid(of_valid), .ex_valid(ex_valid),
    .wb_valid(wb_valid)
);

// File: tb/pipe_interlock_tb_top.sv
`timescale 1ns/1ps
// Bench for pipe_interlock: directed corner sequences plus seeded random
// traffic, checked every cycle against a tag model built from the rules.
module pipe_interlock_tb_top;
    localparam int REG_W = 5;

    typedef struct {
        bit v;
        int s1, s2, d;
        bit rd, wr;
    } tag_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [REG_W-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
    logic in_mem_rd = 1'b0, in_mem_wr = 1'b0, ex_busy = 1'b0;
    logic stall_front, hold_ex, bubble_ex, bubble_wb;
    logic mem_rd_en, mem_wr_en, reg_we, of_valid, ex_valid, wb_valid;
    logic [REG_W-1:0] wb_dst;

    int checks = 0;
    int errors = 0;
    int stall_cnt = 0;
    int hold_cnt = 0;
    int rd_cnt = 0;
    bit done = 0;
    tag_t m_id, m_of, m_ex, m_wb;

    always #4 clk = ~clk;

    pipe_interlock #(.REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src1(in_src1),
        .in_src2(in_src2), .in_dst(in_dst), .in_mem_rd(in_mem_rd),
        .in_mem_wr(in_mem_wr), .ex_busy(ex_busy), .stall_front(stall_front),
        .hold_ex(hold_ex), .bubble_ex(bubble_ex), .bubble_wb(bubble_wb),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .reg_we(reg_we),
        .wb_dst(wb_dst), .of_valid(of_valid), .ex_valid(ex_valid),
        .wb_valid(wb_valid)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit produces(tag_t p, int r);
        return p.v && p.d != 0 && p.d == r;
    endfunction

    function automatic tag_t empty_tag();
        tag_t t;
        t.v = 0; t.s1 = 0; t.s2 = 0; t.d = 0; t.rd = 0; t.wr = 0;
        return t;
    endfunction

    task automatic model_reset();
        m_id = empty_tag(); m_of = empty_tag();
        m_ex = empty_tag(); m_wb = empty_tag();
    endtask

    // One cycle: drive, compare all outputs with the model, advance the model
    task automatic step(bit v, int s1, int s2, int d, bit rd, bit wr, bit busy);
        bit raw, port, busy_a, stall_a, front;
        tag_t nt;
        @(negedge clk);
        in_valid = v; in_src1 = s1[REG_W-1:0]; in_src2 = s2[REG_W-1:0];
        in_dst = d[REG_W-1:0]; in_mem_rd = rd; in_mem_wr = wr; ex_busy = busy;
        #1;
        raw = m_of.v && (produces(m_ex, m_of.s1) || produces(m_wb, m_of.s1) ||
                         produces(m_ex, m_of.s2) || produces(m_wb, m_of.s2));
        port = m_of.v && m_of.rd && m_wb.v && m_wb.wr;
        busy_a = m_ex.v && busy;
        stall_a = !busy_a && (raw || port);
        front = busy_a || stall_a;
        check("R3/R5/R6", "stall_front", stall_front, front);
        check("R5", "hold_ex", hold_ex, busy_a);
        check("R5", "bubble_wb", bubble_wb, busy_a);
        check("R3", "bubble_ex", bubble_ex, stall_a);
        check("R6", "mem_rd_en", mem_rd_en, m_of.v && m_of.rd && !front);
        check("R6", "mem_wr_en", mem_wr_en, m_wb.v && m_wb.wr);
        check("R7", "reg_we", reg_we, m_wb.v && !m_wb.wr && m_wb.d != 0);
        if (m_wb.v) check("R7", "wb_dst", wb_dst, m_wb.d);
        check("R2", "of_valid", of_valid, m_of.v);
        check("R2", "ex_valid", ex_valid, m_ex.v);
        check("R2", "wb_valid", wb_valid, m_wb.v);
        stall_cnt += front;
        hold_cnt += busy_a;
        rd_cnt += (m_of.v && m_of.rd && !front);
        @(posedge clk);
        nt.v = v; nt.s1 = s1; nt.s2 = s2; nt.d = d; nt.rd = rd; nt.wr = wr;
        if (busy_a) m_wb = empty_tag(); else m_wb = m_ex;
        if (!busy_a) begin
            if (stall_a) m_ex = empty_tag(); else m_ex = m_of;
        end
        if (!front) begin
            m_of = m_id;
            m_id = nt;  // R8: new input accepted only when not held
        end
    endtask

    task automatic nop(int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic flush();
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state right after reset
        check("R1", "of_valid", of_valid, 0);
        check("R1", "ex_valid", ex_valid, 0);
        check("R1", "wb_valid", wb_valid, 0);
        check("R1", "stall_front", stall_front, 0);
        check("R1", "reg_we", reg_we, 0);
        check("R1", "mem_wr_en", mem_wr_en, 0);

        // R3: consumer right behind producer waits two cycles
        stall_cnt = 0;
        step(1, 0, 0, 3, 0, 0, 0);
        step(1, 3, 0, 4, 0, 0, 0);
        nop(6);
        check("R3", "raw stall cycles", stall_cnt, 2);
        flush();

        // R4: destination 0 and NOPs never stall
        stall_cnt = 0;
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        nop(5);
        check("R4", "reg0 stall cycles", stall_cnt, 0);
        flush();

        // R4: independent registers do not stall
        stall_cnt = 0;
        step(1, 0, 0, 7, 0, 0, 0);
        step(1, 8, 9, 10, 0, 0, 0);
        nop(5);
        check("R4", "independent stall cycles", stall_cnt, 0);
        flush();

        // R6: memory read two slots behind a memory write stalls one cycle
        stall_cnt = 0; rd_cnt = 0;
        step(1, 0, 0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0);
        nop(6);
        check("R6", "port stall cycles", stall_cnt, 1);
        check("R6", "reads issued", rd_cnt, 1);
        flush();

        // R5: busy for three cycles with a dependent behind it
        stall_cnt = 0; hold_cnt = 0;
        step(1, 0, 0, 5, 0, 0, 0);
        step(1, 5, 0, 6, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);  // producer now enters EX
        step(1, 0, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 1);
        nop(6);
        check("R5", "busy hold cycles", hold_cnt, 3);
        check("R5", "busy plus raw stall cycles", stall_cnt, 5);
        flush();

        // R5: busy with empty execute has no effect
        hold_cnt = 0;
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        check("R5", "busy on empty execute", hold_cnt, 0);

        // R8: inputs during stall are ignored (model comparisons cover it)
        step(1, 0, 0, 2, 0, 0, 0);
        step(1, 2, 2, 3, 0, 0, 0);
        step(1, 3, 1, 1, 1, 1, 0);
        step(1, 1, 1, 1, 0, 0, 0);
        nop(4);
        flush();

        // Random mix over a tiny register set
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 5) != 0, $urandom % 4, $urandom % 4, $urandom % 4,
                 ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        flush();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule